// File: doc/BRIEF.md
# Ultrasonic Ranging Sequencer

This block controls a four-pin ultrasonic distance sensor. While `enable` is high it runs back-to-back measurement cycles. Each cycle drives a trigger pulse and waits for the sensor's echo line to rise. It then times how long the echo stays high, counting 1 µs ticks that are derived from the system clock. Finally it divides that time of flight into a distance.

Every cycle ends with a single-cycle `result_valid` strobe. The strobe carries one of four outcomes:
- a good distance;
- an out-of-range flag, when the computed distance exceeds the usable span;
- a no-object flag, when the echo stays high up to the saturation time that the sensor uses to mean "nothing seen";
- a sensor-fault flag, when the echo never rises at all.

The conversion divides microseconds by 58 for centimetres, or by 148 for inches when `UNIT_INCH` is set. It uses a shift-subtract divider that takes a fixed number of cycles. A holdoff phase spaces triggers so that one ping cannot corrupt the next. All timing parameters are given in ticks of 1 µs, and `TICK_DIV` sets the number of clocks per tick.

Top module: `ultrasonic_ranger`

## Requirements
- R1: `trig` is active high. It stays high for exactly `TRIG_US` ticks (`TRIG_US*TICK_DIV` clock cycles) once per measurement cycle, and is low at all other times.
- R2: A measurement cycle starts only while `enable` is high. With `enable` low at the end of a cycle, `trig` stays low. When `enable` is raised from idle, `trig` rises within `TICK_DIV+3` cycles.
- R3: While `enable` stays high, consecutive rising edges of `trig` are exactly `PERIOD_US` ticks apart. The spacing is never less than that.
- R4: A good result reports `result_dist` = floor(echo high ticks / D). D is 58 when `UNIT_INCH`=0 and 148 when `UNIT_INCH`=1.
- R5: `result_valid` is a one-cycle pulse. After the echo falls, it comes 2 to W+6 cycles later, where W = $clog2(`SAT_US`+1).
- R6: If the echo does not rise within `RISE_WAIT_US` ticks after `trig` falls, the cycle ends with `sensor_fault`=1 and `result_dist`=0. The pulse comes `RISE_WAIT_US*TICK_DIV` cycles (±2) after the fall of `trig`.
- R7: If the echo is still high after `SAT_US` ticks, the cycle ends without waiting for the echo to fall. It reports `no_object`=1 and `result_dist`=0, about `SAT_US*TICK_DIV` cycles after the echo rose. The internal echo count never exceeds `SAT_US`.
- R8: A quotient above `MAX_RANGE` is reported with `out_of_range`=1 and `result_dist`=0. A quotient equal to `MAX_RANGE` is a good result.
- R9: At most one of `no_object`, `out_of_range` and `sensor_fault` is high, and only during `result_valid`.
- R10: While `rst_n` is low, `trig`, `result_valid` and all flags are 0, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run measurement cycles while high |
| echo | input | 1 | Asynchronous echo line from the sensor |
| trig | output | 1 | Trigger pulse to the sensor |
| result_valid | output | 1 | One-cycle strobe marking a finished cycle |
| result_dist | output | DIST_W | Distance in the selected unit; 0 unless the result is good |
| no_object | output | 1 | Echo saturated, nothing in range |
| out_of_range | output | 1 | Distance beyond `MAX_RANGE` |
| sensor_fault | output | 1 | Echo never rose |

## Verification
A good result is due a fixed number of cycles after the echo falls: two synchroniser stages, one cycle to start the divider, W divider steps and one report register. The bench timestamps each echo fall and each strobe, and accepts only the window in R5.

Fault and no-object results are due a whole number of ticks after the fall of `trig` or the rise of the echo, so the bench compares those gaps in cycles to `TICK_DIV` times the parameter. Trigger width and spacing are measured at negative edges as exact cycle counts.

// File: rtl/ranger_pkg.sv
package ranger_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TRIG, ST_WAIT, ST_MEAS, ST_CONV, ST_HOLD
  } rstate_e;

  typedef enum logic [1:0] {
    OUT_GOOD, OUT_FAR, OUT_NONE, OUT_FAULT
  } outcome_e;
endpackage

// File: rtl/ranger_tick.sv
module ranger_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/ranger_echo_sync.sv
module ranger_echo_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic echo_in,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], echo_in};
  end
  assign rise =  sh[1] & ~sh[2];
  assign fall = ~sh[1] &  sh[2];
endmodule

// File: rtl/ranger_divider.sv
module ranger_divider #(
  parameter int unsigned NW      = 16,
  parameter int unsigned DIVISOR = 58
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int RW = $clog2(DIVISOR) + 1;
  localparam int SW = $clog2(NW + 1);
  localparam logic [RW-1:0] DV = RW'(DIVISOR);

  logic [RW-1:0] rem;
  logic [RW-1:0] trial;
  logic [SW-1:0] steps;
  logic          busy;

  // shift in the next dividend bit behind the partial remainder
  assign trial = {rem[RW-2:0], quotient[NW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      quotient <= '0;
      steps    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quotient <= dividend;
        rem      <= '0;
        steps    <= SW'(NW);
        busy     <= 1'b1;
      end else if (busy) begin
        if (trial >= DV) begin
          rem      <= trial - DV;
          quotient <= {quotient[NW-2:0], 1'b1};
        end else begin
          rem      <= trial;
          quotient <= {quotient[NW-2:0], 1'b0};
        end
        steps <= steps - 1'b1;
        if (steps == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ultrasonic_ranger.sv
module ultrasonic_ranger
  import ranger_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 50,
  parameter int unsigned TRIG_US      = 12,
  parameter int unsigned RISE_WAIT_US = 1000,
  parameter int unsigned SAT_US       = 38000,
  parameter int unsigned PERIOD_US    = 60000,
  parameter int unsigned MAX_RANGE    = 400,
  parameter bit          UNIT_INCH    = 1'b0,
  parameter int unsigned DIST_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              echo,
  output logic              trig,
  output logic              result_valid,
  output logic [DIST_W-1:0] result_dist,
  output logic              no_object,
  output logic              out_of_range,
  output logic              sensor_fault
);
  localparam int unsigned DIVISOR = UNIT_INCH ? 148 : 58;
  localparam int CW = $clog2(SAT_US + 1);
  localparam int TW = $clog2(((TRIG_US > RISE_WAIT_US) ? TRIG_US : RISE_WAIT_US) + 1);
  localparam int PW = $clog2(PERIOD_US + 1);
  localparam logic [CW-1:0] SAT_C   = CW'(SAT_US);
  localparam logic [CW-1:0] MAXR_C  = CW'(MAX_RANGE);
  localparam logic [TW-1:0] TRIG_L  = TW'(TRIG_US - 1);
  localparam logic [TW-1:0] WAIT_L  = TW'(RISE_WAIT_US - 1);
  localparam logic [PW-1:0] PER_L   = PW'(PERIOD_US - 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic tick, e_rise, e_fall;
  logic div_start, div_done;
  logic [CW-1:0] quot;

  rstate_e       state, nstate;
  logic [TW-1:0] wcnt;
  logic [CW-1:0] ecnt;
  logic [PW-1:0] pcnt;
  logic          rep_fire;
  outcome_e      rep_kind;

  ranger_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_ni), .tick(tick)
  );

  ranger_echo_sync u_sync (
    .clk(clk), .rst_n(rst_ni), .echo_in(echo), .rise(e_rise), .fall(e_fall)
  );

  ranger_divider #(.NW(CW), .DIVISOR(DIVISOR)) u_div (
    .clk(clk), .rst_n(rst_ni), .start(div_start), .dividend(ecnt),
    .done(div_done), .quotient(quot)
  );

  always_comb begin
    nstate    = state;
    div_start = 1'b0;
    rep_fire  = 1'b0;
    rep_kind  = OUT_GOOD;
    case (state)
      ST_IDLE: if (tick && enable) nstate = ST_TRIG;
      ST_TRIG: if (tick && wcnt == TRIG_L) nstate = ST_WAIT;
      ST_WAIT: begin
        if (e_rise) begin
          nstate = ST_MEAS;
        end else if (tick && wcnt == WAIT_L) begin
          nstate   = ST_HOLD;
          rep_fire = 1'b1;
          rep_kind = OUT_FAULT;
        end
      end
      ST_MEAS: begin
        if (e_fall) begin
          nstate    = ST_CONV;
          div_start = 1'b1;
        end else if (tick && ecnt == SAT_C - 1'b1) begin
          nstate   = ST_HOLD;
          rep_fire = 1'b1;
          rep_kind = OUT_NONE;
        end
      end
      ST_CONV: begin
        if (div_done) begin
          nstate   = ST_HOLD;
          rep_fire = 1'b1;
          rep_kind = (quot > MAXR_C) ? OUT_FAR : OUT_GOOD;
        end
      end
      ST_HOLD: if (tick && pcnt == PER_L) nstate = enable ? ST_TRIG : ST_IDLE;
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      trig         <= 1'b0;
      wcnt         <= '0;
      ecnt         <= '0;
      pcnt         <= '0;
      result_valid <= 1'b0;
      result_dist  <= '0;
      no_object    <= 1'b0;
      out_of_range <= 1'b0;
      sensor_fault <= 1'b0;
    end else begin
      state <= nstate;
      trig  <= (nstate == ST_TRIG);

      if (nstate != state)
        wcnt <= '0;
      else if (tick && (state == ST_TRIG || state == ST_WAIT))
        wcnt <= wcnt + 1'b1;

      if (nstate == ST_MEAS && state != ST_MEAS)
        ecnt <= '0;
      else if (state == ST_MEAS && tick && ecnt != SAT_C)
        ecnt <= ecnt + 1'b1;

      if (nstate == ST_TRIG && state != ST_TRIG)
        pcnt <= '0;
      else if (tick && pcnt != PER_L)
        pcnt <= pcnt + 1'b1;

      result_valid <= rep_fire;
      no_object    <= rep_fire && (rep_kind == OUT_NONE);
      out_of_range <= rep_fire && (rep_kind == OUT_FAR);
      sensor_fault <= rep_fire && (rep_kind == OUT_FAULT);
      if (rep_fire)
        result_dist <= (rep_kind == OUT_GOOD) ? DIST_W'(quot) : '0;
    end
  end
endmodule

// File: rtl/ranger_checker.sv
module ranger_checker #(
  parameter int unsigned TRIG_CYC   = 600,
  parameter int unsigned PERIOD_CYC = 3000000,
  parameter int unsigned SAT_US     = 38000,
  parameter int unsigned MAX_RANGE  = 400,
  parameter int          CW         = 16,
  parameter int          DIST_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              result_valid,
  input logic [DIST_W-1:0] result_dist,
  input logic              no_object,
  input logic              out_of_range,
  input logic              sensor_fault,
  input logic [CW-1:0]     ecnt
);
  int unsigned hi_cnt;
  int unsigned gap;
  logic        seen;
  logic        any_flag;
  assign any_flag = no_object | out_of_range | sensor_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 0;
      gap    <= 0;
      seen   <= 1'b0;
    end else begin
      hi_cnt <= trig ? hi_cnt + 1 : 0;
      if (trig && hi_cnt == 0) begin
        gap  <= 1;
        seen <= 1'b1;
      end else if (gap < PERIOD_CYC + 1) begin
        gap <= gap + 1;
      end
    end
  end

  // R1
  trig_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trig) && hi_cnt != 0) |-> hi_cnt == TRIG_CYC);
  // R3
  trig_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && hi_cnt == 0 && seen) |-> gap >= PERIOD_CYC);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R9
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $onehot0({no_object, out_of_range, sensor_fault}));
  // R9
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> !any_flag);
  // R8
  zero_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && any_flag) |-> result_dist == '0);
  // R8
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !any_flag) |-> result_dist <= DIST_W'(MAX_RANGE));
  // R7
  echo_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= CW'(SAT_US));
endmodule

bind ultrasonic_ranger ranger_checker #(
  .TRIG_CYC(TRIG_US * TICK_DIV), .PERIOD_CYC(PERIOD_US * TICK_DIV),
  .SAT_US(SAT_US), .MAX_RANGE(MAX_RANGE), .CW(CW), .DIST_W(DIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .result_valid(result_valid),
  .result_dist(result_dist), .no_object(no_object), .out_of_range(out_of_range),
  .sensor_fault(sensor_fault), .ecnt(ecnt)
);

// File: tb/tb_ultrasonic_ranger.sv
module tb_ultrasonic_ranger;
  localparam int DIV = 2;
  localparam int TRIGW = 10;
  localparam int RWAIT = 100;
  localparam int SAT = 3000;
  localparam int PER = 4000;
  localparam int MAXR = 40;
  localparam int DW = 16;
  localparam int W = $clog2(SAT + 1);
  localparam int NV = 8;
  // kind: 0 echo pulse of US microseconds, 1 no echo, 2 echo held past saturation
  localparam int VEC_KIND [NV] = '{0, 0, 0, 0, 0, 2, 1, 0};
  localparam int VEC_US   [NV] = '{319, 29, 1015, 2349, 2407, 0, 0, 1943};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic echo = 1'b0;
  logic trig, result_valid, no_object, out_of_range, sensor_fault;
  logic [DW-1:0] result_dist;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ultrasonic_ranger #(
    .TICK_DIV(DIV), .TRIG_US(TRIGW), .RISE_WAIT_US(RWAIT), .SAT_US(SAT),
    .PERIOD_US(PER), .MAX_RANGE(MAXR), .UNIT_INCH(1'b0), .DIST_W(DW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .echo(echo), .trig(trig),
    .result_valid(result_valid), .result_dist(result_dist), .no_object(no_object),
    .out_of_range(out_of_range), .sensor_fault(sensor_fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t_rise, t_prev, t_fall, t_er, t_ef, t_v, n;
    bit got, v_after;
    int g_dist, g_no, g_far, g_flt, exp_cm, exp_far;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(trig == 1'b0 && result_valid == 1'b0, "R10 reset outputs", {trig, result_valid}, 0);
    check({no_object, out_of_range, sensor_fault} == 3'b0, "R10 reset flags",
          {no_object, out_of_range, sensor_fault}, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    t_prev = 0;

    for (int i = 0; i < NV; i++) begin
      while (!trig) @(negedge clk);
      t_rise = cyc;
      if (i > 0) check(t_rise - t_prev == PER * DIV, "R3 trigger spacing", t_rise - t_prev, PER * DIV);
      t_prev = t_rise;
      while (trig) @(negedge clk);
      t_fall = cyc;
      check(t_fall - t_rise == TRIGW * DIV, "R1 trigger width", t_fall - t_rise, TRIGW * DIV);
      repeat (20) @(negedge clk);
      got = 1'b0;
      t_er = 0; t_ef = 0; t_v = 0; v_after = 1'b0;
      g_dist = 0; g_no = 0; g_far = 0; g_flt = 0;
      fork
        begin
          if (VEC_KIND[i] != 1) begin
            echo = 1'b1;
            t_er = cyc;
            repeat (((VEC_KIND[i] == 2) ? (SAT + 150) : VEC_US[i]) * DIV) @(negedge clk);
            echo = 1'b0;
            t_ef = cyc;
          end
        end
        begin
          n = 0;
          while (!got && n < (SAT + 400) * DIV) begin
            @(negedge clk);
            n++;
            if (result_valid) begin
              got = 1'b1;
              t_v = cyc;
              g_dist = int'(result_dist);
              g_no = int'(no_object); g_far = int'(out_of_range); g_flt = int'(sensor_fault);
            end
          end
          @(negedge clk);
          v_after = result_valid;
        end
      join
      check(got, "R5 result strobe seen", int'(got), 1);
      check(!v_after, "R5 strobe lasts one cycle", int'(v_after), 0);
      if (VEC_KIND[i] == 0) begin
        exp_cm = VEC_US[i] / 58;
        exp_far = (exp_cm > MAXR) ? 1 : 0;
        // R4 distance, R8 range limit
        check(g_dist == (exp_far ? 0 : exp_cm), "R4 distance", g_dist, exp_far ? 0 : exp_cm);
        check(g_far == exp_far, "R8 out of range flag", g_far, exp_far);
        check(g_no == 0 && g_flt == 0, "R9 no other flag", g_no + g_flt, 0);
        check(t_v - t_ef >= 2 && t_v - t_ef <= W + 6, "R5 result latency", t_v - t_ef, W + 3);
      end else if (VEC_KIND[i] == 2) begin
        check(g_no == 1 && g_dist == 0, "R7 no object flag", g_no, 1);
        check(g_far == 0 && g_flt == 0, "R9 single flag", g_far + g_flt, 0);
        check(t_v - t_er >= SAT * DIV - 2 && t_v - t_er <= SAT * DIV + DIV + 4,
              "R7 saturation time", t_v - t_er, SAT * DIV);
      end else begin
        check(g_flt == 1 && g_dist == 0, "R6 fault flag", g_flt, 1);
        check(g_no == 0 && g_far == 0, "R9 single flag", g_no + g_far, 0);
        check(t_v - t_fall >= RWAIT * DIV - 2 && t_v - t_fall <= RWAIT * DIV + 2,
              "R6 fault time", t_v - t_fall, RWAIT * DIV);
      end
    end

    // R2 no trigger while disabled
    enable = 1'b0;
    n = 0;
    repeat (2 * PER * DIV) begin
      @(negedge clk);
      if (trig) n++;
    end
    check(n == 0, "R2 idle while disabled", n, 0);
    enable = 1'b1;
    n = 0;
    while (!trig && n < DIV + 10) begin
      @(negedge clk);
      n++;
    end
    check(trig && n <= DIV + 3, "R2 restart delay", n, DIV);

    // R10 reset in the middle of a trigger
    #3 rst_n = 1'b0;
    #1;
    check(trig == 1'b0 && result_valid == 1'b0, "R10 async clear", int'(trig), 0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule